// File: doc/BRIEF.md
# SIMT Lane Enable Mask Controller

This block tracks which lanes of one subgroup are enabled while the subgroup runs structured control flow. A sequencer hands it one control event per cycle: open/flip/close of a two-sided branch, or open/continue/break/close of a loop. Each event carries one condition bit per lane. The block updates the enabled-lane mask and saves enclosing masks on a fixed-depth nesting stack. It also tells the sequencer whether a branch was uniform or split, whether the then-side or else-side can be skipped, and whether a loop close leaves the loop or goes around again.

Only lanes that are enabled when a branch is evaluated take part in its decision. A lane that continues drops out for the rest of the current iteration. A lane that breaks stays out until the whole loop closes. A loop closes when no lane is left to run another iteration. Misuse of the stack raises a sticky error: a push when the stack is full, a pop when it is empty, or an event that does not match the innermost open construct.

Top module: `simt_mask_ctrl`

## Requirements
- R1: While and after a synchronous active-high reset, every lane is enabled, the stack is empty, the error flag is clear and all event pulses are low.
- R2: A branch-open event (ev_op 1) sets the mask to prior mask AND condition and pushes the prior mask and that then-lane set. Condition bits of disabled lanes have no effect.
- R3: One cycle after a branch-open, br_uniform is high if all enabled lanes agree, including the case of no enabled lane, and br_diverged is high otherwise. Both are low after every other event.
- R4: skip_then pulses one cycle after a branch-open in which no enabled lane has a true condition.
- R5: A branch-flip event (ev_op 2) sets the mask to saved mask AND NOT then-lanes. skip_else pulses when that set is empty.
- R6: A branch-close event (ev_op 3) restores the saved mask and pops the entry.
- R7: A loop-open (ev_op 4) pushes the current mask as the entry mask with an empty break set. A continue (ev_op 5) disables the lanes whose condition is set, only until the next iteration.
- R8: A break (ev_op 6) disables the lanes whose condition is set and adds them to the break set, so they stay disabled on later iterations.
- R9: A loop-close (ev_op 7) sets the mask to entry AND NOT break set when that is non-empty, with loop_exit low. Otherwise it pops the entry, restores the entry mask and pulses loop_exit.
- R10: A branch-open or loop-open with the stack full sets stack_err and changes neither mask nor stack, with no pulses.
- R11: A flip/close with no branch entry on top, or a continue/break/loop-close with no loop entry on top, sets stack_err and changes nothing.
- R12: stack_err stays set until reset.
- R13: With ev_valid low or ev_op 0, mask, stack and error are unchanged and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Control event present this cycle |
| ev_op | input | 3 | Event code (see R2 to R13) |
| ev_cond | input | LANES | Per-lane condition bits |
| active_mask | output | LANES | Registered enabled-lane mask |
| br_uniform | output | 1 | Pulse: last branch-open was uniform |
| br_diverged | output | 1 | Pulse: last branch-open split the lanes |
| skip_then | output | 1 | Pulse: then-side needs no lane |
| skip_else | output | 1 | Pulse: else-side needs no lane |
| loop_exit | output | 1 | Pulse: loop-close left the loop |
| stack_err | output | 1 | Sticky nesting error |

## Verification
Each event is sampled at one rising edge, and every result it causes is registered at that same edge. So the mask, the pulses and the error flag are all due exactly one cycle after the event. The bench drives an event on a falling edge and compares all outputs at the next falling edge against its own model. It then drives the next event, so each pulse is seen only in the cycle it belongs to. Idle cycles are checked the same way, which shows that pulses clear after one cycle and that the state holds.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_BR_OPEN = 3'd1,
        OP_BR_FLIP = 3'd2,
        OP_BR_CLOSE= 3'd3,
        OP_LP_OPEN = 3'd4,
        OP_LP_CONT = 3'd5,
        OP_LP_BRK  = 3'd6,
        OP_LP_CLOSE= 3'd7
    } op_e;

    // kind bit stored with each nesting entry
    localparam logic KIND_BR = 1'b0;
    localparam logic KIND_LP = 1'b1;

endpackage

// File: rtl/simt_lane_vote.sv
module simt_lane_vote #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] cur,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] taken,
    output logic [LANES-1:0] dropped,
    output logic             none_true,
    output logic             none_false
);
    // per-lane split of the enabled set
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign taken[i]   = cur[i] &  cond[i];
        assign dropped[i] = cur[i] & ~cond[i];
    end

    assign none_true  = ~|taken;
    assign none_false = ~|dropped;
endmodule

// File: rtl/simt_nest_stack.sv
module simt_nest_stack #(
    parameter int WIDTH = 17,
    parameter int DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic                          pop,
    input  logic                          upd,
    input  logic [WIDTH-1:0]              din,
    output logic [WIDTH-1:0]              top,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [CW-1:0]    cnt_q, cnt_d;
    logic [CW-1:0]    top_idx;
    logic [CW-1:0]    wr_idx;

    always_comb begin
        top_idx = cnt_q - CW'(1);
        wr_idx  = cnt_q;
    end

    assign top   = (cnt_q == '0) ? '0 : mem_q[top_idx[AW-1:0]];
    assign count = cnt_q;

    always_comb begin
        mem_d = mem_q;
        cnt_d = cnt_q;
        if (push) begin
            mem_d[wr_idx[AW-1:0]] = din;
            cnt_d = cnt_q + CW'(1);
        end else if (pop) begin
            cnt_d = cnt_q - CW'(1);
        end else if (upd) begin
            mem_d[top_idx[AW-1:0]] = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            mem_q <= mem_d;
        end
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(push && cnt_q == CW'(DEPTH)));
    // R11
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        !((pop || upd) && cnt_q == '0));
    // R10
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/simt_mask_ctrl.sv
module simt_mask_ctrl
    import simt_mask_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  logic [2:0]       ev_op,
    input  logic [LANES-1:0] ev_cond,
    output logic [LANES-1:0] active_mask,
    output logic             br_uniform,
    output logic             br_diverged,
    output logic             skip_then,
    output logic             skip_else,
    output logic             loop_exit,
    output logic             stack_err
);
    localparam int W  = 1 + 2*LANES;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [LANES-1:0] mask;
        logic             err;
        logic             unif;
        logic             div;
        logic             st;
        logic             se;
        logic             lx;
    } ctrl_t;

    ctrl_t ctrl_q, ctrl_d;

    logic [LANES-1:0] taken, dropped;
    logic             none_true, none_false;

    logic             s_push, s_pop, s_upd;
    logic [W-1:0]     s_din, s_top;
    logic [CW-1:0]    s_cnt;

    logic             top_kind;
    logic [LANES-1:0] top_a, top_b;
    logic             have_br, have_lp, full;
    logic [LANES-1:0] else_set, resume_set;
    op_e              op;

    simt_lane_vote #(.LANES(LANES)) u_vote (
        .cur        (ctrl_q.mask),
        .cond       (ev_cond),
        .taken      (taken),
        .dropped    (dropped),
        .none_true  (none_true),
        .none_false (none_false)
    );

    simt_nest_stack #(.WIDTH(W), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (s_push),
        .pop   (s_pop),
        .upd   (s_upd),
        .din   (s_din),
        .top   (s_top),
        .count (s_cnt)
    );

    assign top_kind   = s_top[W-1];
    assign top_a      = s_top[2*LANES-1:LANES];
    assign top_b      = s_top[LANES-1:0];
    assign have_br    = (s_cnt != '0) && (top_kind == KIND_BR);
    assign have_lp    = (s_cnt != '0) && (top_kind == KIND_LP);
    assign full       = (s_cnt == CW'(DEPTH));
    assign else_set   = top_a & ~top_b;
    assign resume_set = top_a & ~top_b;
    assign op         = op_e'(ev_op);

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.unif = 1'b0;
        ctrl_d.div  = 1'b0;
        ctrl_d.st   = 1'b0;
        ctrl_d.se   = 1'b0;
        ctrl_d.lx   = 1'b0;
        s_push      = 1'b0;
        s_pop       = 1'b0;
        s_upd       = 1'b0;
        s_din       = '0;
        if (ev_valid) begin
            unique case (op)
                OP_BR_OPEN: begin
                    if (full) ctrl_d.err = 1'b1;
                    else begin
                        s_push      = 1'b1;
                        s_din       = {KIND_BR, ctrl_q.mask, taken};
                        ctrl_d.mask = taken;
                        ctrl_d.unif = none_true | none_false;
                        ctrl_d.div  = ~(none_true | none_false);
                        ctrl_d.st   = none_true;
                    end
                end
                OP_BR_FLIP: begin
                    if (!have_br) ctrl_d.err = 1'b1;
                    else begin
                        ctrl_d.mask = else_set;
                        ctrl_d.se   = (else_set == '0);
                    end
                end
                OP_BR_CLOSE: begin
                    if (!have_br) ctrl_d.err = 1'b1;
                    else begin
                        s_pop       = 1'b1;
                        ctrl_d.mask = top_a;
                    end
                end
                OP_LP_OPEN: begin
                    if (full) ctrl_d.err = 1'b1;
                    else begin
                        s_push = 1'b1;
                        s_din  = {KIND_LP, ctrl_q.mask, {LANES{1'b0}}};
                    end
                end
                OP_LP_CONT: begin
                    if (!have_lp) ctrl_d.err = 1'b1;
                    else ctrl_d.mask = dropped;
                end
                OP_LP_BRK: begin
                    if (!have_lp) ctrl_d.err = 1'b1;
                    else begin
                        ctrl_d.mask = dropped;
                        s_upd       = 1'b1;
                        s_din       = {KIND_LP, top_a, top_b | taken};
                    end
                end
                OP_LP_CLOSE: begin
                    if (!have_lp) ctrl_d.err = 1'b1;
                    else if (resume_set != '0) begin
                        ctrl_d.mask = resume_set;
                    end else begin
                        s_pop       = 1'b1;
                        ctrl_d.mask = top_a;
                        ctrl_d.lx   = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            ctrl_q.mask <= '1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign active_mask = ctrl_q.mask;
    assign br_uniform  = ctrl_q.unif;
    assign br_diverged = ctrl_q.div;
    assign skip_then   = ctrl_q.st;
    assign skip_else   = ctrl_q.se;
    assign loop_exit   = ctrl_q.lx;
    assign stack_err   = ctrl_q.err;

    // R1
    reset_mask_chk: assert property (@(posedge clk)
        rst |=> (active_mask == '1 && !stack_err));
    // R2
    open_no_gain_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_op == 3'd1) |=> ((active_mask & ~$past(active_mask)) == '0));
    // R3
    uni_div_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(br_uniform && br_diverged));
    // R4
    skip_then_empty_chk: assert property (@(posedge clk) disable iff (rst)
        skip_then |-> (active_mask == '0));
    // R5
    skip_else_empty_chk: assert property (@(posedge clk) disable iff (rst)
        skip_else |-> (active_mask == '0));
    // R9
    exit_cause_chk: assert property (@(posedge clk) disable iff (rst)
        loop_exit |-> ($past(ev_valid) && $past(ev_op) == 3'd7));
    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stack_err |=> stack_err);
    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ev_valid |=> ($stable(active_mask) && !br_uniform && !br_diverged && !loop_exit));
endmodule

// File: tb/simt_mask_ctrl_tb.sv
`timescale 1ns/1ps
module simt_mask_ctrl_tb;
    localparam int L = 16;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ev_valid = 1'b0;
    logic [2:0]   ev_op = 3'd0;
    logic [L-1:0] ev_cond = '0;
    logic [L-1:0] active_mask;
    logic         br_uniform, br_diverged, skip_then, skip_else, loop_exit, stack_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    simt_mask_ctrl #(.LANES(L), .DEPTH(D)) u_dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_op(ev_op), .ev_cond(ev_cond),
        .active_mask(active_mask), .br_uniform(br_uniform), .br_diverged(br_diverged),
        .skip_then(skip_then), .skip_else(skip_else), .loop_exit(loop_exit),
        .stack_err(stack_err)
    );

    always #10 clk = ~clk;

    // bench model
    logic [L-1:0] m_mask;
    int           m_sp;
    bit           m_err;
    bit           m_k [D];
    logic [L-1:0] m_a [D];
    logic [L-1:0] m_b [D];
    bit e_un, e_dv, e_st, e_se, e_lx, e_errnow;
    string e_tag;

    task automatic model_reset();
        m_mask = '1; m_sp = 0; m_err = 0;
        e_un = 0; e_dv = 0; e_st = 0; e_se = 0; e_lx = 0; e_errnow = 0;
    endtask

    task automatic model_step(input bit v, input logic [2:0] op, input logic [L-1:0] c);
        logic [L-1:0] t, r;
        e_un = 0; e_dv = 0; e_st = 0; e_se = 0; e_lx = 0; e_errnow = 0;
        e_tag = "R13";
        if (!v || op == 3'd0) return;
        case (op)
            3'd1, 3'd4: begin
                if (m_sp == D) begin m_err = 1; e_errnow = 1; e_tag = "R10"; end
                else begin
                    t = m_mask & c;
                    m_k[m_sp] = (op == 3'd4);
                    m_a[m_sp] = m_mask;
                    m_b[m_sp] = (op == 3'd4) ? '0 : t;
                    m_sp++;
                    if (op == 3'd1) begin
                        e_un = (t == '0) || (t == m_mask);
                        e_dv = !e_un;
                        e_st = (t == '0);
                        m_mask = t;
                        e_tag = "R2";
                    end else e_tag = "R7";
                end
            end
            3'd2, 3'd3: begin
                if (m_sp == 0 || m_k[m_sp-1]) begin m_err = 1; e_errnow = 1; e_tag = "R11"; end
                else if (op == 3'd2) begin
                    m_mask = m_a[m_sp-1] & ~m_b[m_sp-1];
                    e_se = (m_mask == '0);
                    e_tag = "R5";
                end else begin
                    m_mask = m_a[m_sp-1]; m_sp--; e_tag = "R6";
                end
            end
            default: begin
                if (m_sp == 0 || !m_k[m_sp-1]) begin m_err = 1; e_errnow = 1; e_tag = "R11"; end
                else if (op == 3'd5) begin
                    m_mask = m_mask & ~c; e_tag = "R7";
                end else if (op == 3'd6) begin
                    m_b[m_sp-1] = m_b[m_sp-1] | (m_mask & c);
                    m_mask = m_mask & ~c; e_tag = "R8";
                end else begin
                    r = m_a[m_sp-1] & ~m_b[m_sp-1];
                    e_tag = "R9";
                    if (r != '0) m_mask = r;
                    else begin m_mask = m_a[m_sp-1]; m_sp--; e_lx = 1; end
                end
            end
        endcase
    endtask

    task automatic chk1(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk1(e_tag, active_mask, m_mask);
        chk1("R3", L'(br_uniform), L'(e_un));
        chk1("R3", L'(br_diverged), L'(e_dv));
        chk1("R4", L'(skip_then), L'(e_st));
        chk1("R5", L'(skip_else), L'(e_se));
        chk1("R9", L'(loop_exit), L'(e_lx));
        chk1(e_errnow ? e_tag : "R12", L'(stack_err), L'(m_err));
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic send(input bit v, input logic [2:0] op, input logic [L-1:0] c);
        ev_valid = v; ev_op = op; ev_cond = c;
        model_step(v, op, c);
        @(negedge clk);
        ev_valid = 0; ev_op = 3'd0; ev_cond = '0;
        check_all();
    endtask

    task automatic do_reset();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        model_reset();
        e_tag = "R1";
        check_all();
    endtask

    function automatic logic [L-1:0] rand_cond();
        int sel = $urandom_range(0, 5);
        case (sel)
            0: return '1;
            1: return '0;
            2: return L'($urandom) | L'($urandom);
            default: return L'($urandom);
        endcase
    endfunction

    initial begin
        logic [2:0] op;
        void'($urandom(32'h5eed_1234));
        model_reset();
        @(negedge clk);
        do_reset();

        // R1: idle after reset holds all lanes
        send(0, 3'd0, '0);

        // R2/R3: disabled lanes' conditions are ignored in the vote
        send(1, 3'd1, 16'h00FF);            // mask 00FF, diverged
        send(1, 3'd1, 16'hFF0F);            // active 00FF -> 000F, split
        send(1, 3'd1, 16'hF00F);            // active 000F all true -> uniform
        send(1, 3'd3, '0);
        send(1, 3'd2, 16'h0000);            // else of 000F -> 00F0
        send(1, 3'd3, '0);
        send(1, 3'd3, '0);                  // back to all ones
        // R4: none true -> skip_then, R5: flip with all taken -> skip_else
        send(1, 3'd1, 16'h0000);
        send(1, 3'd3, '0);
        send(1, 3'd1, 16'hFFFF);
        send(1, 3'd2, '0);
        send(1, 3'd3, '0);

        // R7/R8/R9: continue returns next iteration, break stays out
        send(1, 3'd4, '0);
        send(1, 3'd5, 16'h000F);            // continue lanes 0..3
        send(1, 3'd6, 16'h00F0);            // break lanes 4..7
        send(1, 3'd7, '0);                  // resume FF0F
        send(1, 3'd6, 16'hFFFF);            // everyone breaks
        send(1, 3'd7, '0);                  // exit, restore FFFF

        // R13: op 0 with valid has no effect
        send(1, 3'd0, 16'hAAAA);

        // random legal stream (R2..R9, R13)
        for (int n = 0; n < 3000; n++) begin
            int pick = $urandom_range(0, 9);
            if (pick == 0) begin
                send(0, 3'($urandom_range(0, 7)), rand_cond());
                continue;
            end
            if (m_sp == 0) op = ($urandom_range(0, 1) != 0) ? 3'd1 : 3'd4;
            else if (m_sp < D && pick < 4) op = ($urandom_range(0, 1) != 0) ? 3'd1 : 3'd4;
            else if (!m_k[m_sp-1]) op = ($urandom_range(0, 1) != 0) ? 3'd2 : 3'd3;
            else op = 3'($urandom_range(5, 7));
            send(1, op, rand_cond());
        end

        // R10: overflow
        do_reset();
        for (int i = 0; i < D; i++) send(1, 3'd1, 16'hFFF0);
        send(1, 3'd4, '0);
        // R12: error stays through further events
        send(1, 3'd3, '0);
        send(0, 3'd0, '0);
        // R1: reset clears error
        do_reset();
        // R11: close on empty, continue inside a branch, flip inside a loop
        send(1, 3'd3, '0);
        do_reset();
        send(1, 3'd1, 16'h0F0F);
        send(1, 3'd5, 16'hFFFF);
        do_reset();
        send(1, 3'd4, '0);
        send(1, 3'd2, '0);
        send(1, 3'd7, '0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule